// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base G to an exponent E modulo an odd modulus M and leaves Y = G^E mod M in a result memory. A host loads the base, the modulus and the exponent one word at a time through a single word-wide port. It picks the operand length as a whole number of words, pulses `start`, and reads the result words back once `done` has pulsed. The word width and the largest operand length are parameters. The length is taken at run time, so each operation can use a different one.

Internally every product is a radix-2 Montgomery multiplication, produced by a bit-serial multiplier submodule. A separate shift-and-subtract reducer brings the base into residue form (G·2^n mod M) and forms the residue of one (2^n mod M). The sequencer then walks the exponent. It first skips the leading zero bits. From the highest set bit down to bit 0 it squares the running value on every bit, and multiplies by the residue base whenever the bit is 1. A last Montgomery product with the plain integer 1 strips the 2^n factor before the value is offered to the host.

Top module: `modexp_engine`

## Requirements
- R1: After reset `busy` and `done` are low and every word of the result memory reads 0.
- R2: With `host_we` high while idle, `host_wdata` is stored at word `host_addr` of the memory chosen by `host_sel` (0 base, 1 modulus, 2 exponent; word 0 holds the least significant bits). `host_rdata` shows that word combinationally, and `host_sel` = 3 selects the result memory, which cannot be written by the host.
- R3: For an odd modulus M with 1 < M < 2^n, where n = `n_words` × word width, the result memory holds G^E mod M when `done` pulses.
- R4: An exponent of zero gives a result of 1 (1 mod M).
- R5: A base that is equal to or larger than M gives the same result as the base reduced modulo M.
- R6: `busy` rises on the cycle after an accepted `start`. `done` is high for exactly one cycle, and the result is already in place while it is high. `busy` falls on the cycle after `done`.
- R7: Host writes issued while `busy` is high change no memory.
- R8: A `start` pulse issued while `busy` is high is ignored, and no second operation follows.
- R9: Words at or above `n_words` in the base, modulus and exponent memories have no effect on the result, so the operand length can change from one operation to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exponentiation (accepted only when idle) |
| n_words | input | $clog2(MAX_WORDS+1) | Operand length in words, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host word write enable |
| host_sel | input | 2 | Memory select: 0 base, 1 modulus, 2 exponent, 3 result |
| host_addr | input | $clog2(MAX_WORDS) | Word index |
| host_wdata | input | WORD_W | Write data |
| host_rdata | output | WORD_W | Read data of the selected word |

## Verification
The base-2 group with modulus 157 is driven with exponents 0 and 1 and with short values. These cases separate a missing residue conversion or a missing final multiply-by-one from a correct schedule, because each of those faults gives a value scaled by a power of 2^n. An all-ones exponent and a full-length exponent with its top bit set exercise the multiply-on-one path on every bit and the scan boundary at the top bit. Bases larger than the modulus and garbage in the upper words show whether the reduction and the length masking take effect. Random lengths, moduli and exponents are checked against a square-and-multiply model in the bench, and a run with writes and a start injected mid-operation shows that the stored operands are frozen while the engine is busy.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_EXP  = 2'd2,
    SEL_RES  = 2'd3
  } mem_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RED_BASE,
    ST_RED_ONE,
    ST_SCAN,
    ST_SQR,
    ST_MUL,
    ST_OUT,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/modexp_store.sv
module modexp_store #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              sel,
  input  logic [AW-1:0]           addr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORDS*WORD_W-1:0] base_v,
  output logic [WORDS*WORD_W-1:0] mod_v,
  output logic [WORDS*WORD_W-1:0] exp_v,
  output logic [WORD_W-1:0]       rdata_op
);
  localparam int VW = WORDS * WORD_W;

  logic [VW-1:0] vec_q [3];
  logic          addr_ok;

  assign addr_ok = int'(addr) < WORDS;

  // one operand memory per select code; the result code maps to none
  for (genvar k = 0; k < 3; k++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[k] <= '0;
      end else if (wr_en && addr_ok && (int'(sel) == k)) begin
        vec_q[k][int'(addr)*WORD_W +: WORD_W] <= wdata;
      end
    end
  end

  assign base_v = vec_q[0];
  assign mod_v  = vec_q[1];
  assign exp_v  = vec_q[2];

  always_comb begin
    rdata_op = '0;
    if (addr_ok && sel != 2'd3) rdata_op = vec_q[sel][int'(addr)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/modexp_reduce.sv
module modexp_reduce #(
  parameter int W   = 64,
  parameter int NBW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   val,
  input  logic [W-1:0]   m,
  input  logic [NBW-1:0] nbits,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   res
);
  // computes (val * 2^nbits) mod m by feeding val followed by nbits zeros
  function automatic logic [W:0] red_step(logic [W:0] r, logic b, logic [W-1:0] md);
    logic [W+1:0] t;
    t = {r, b};
    if (t >= {2'b00, md}) t = t - {2'b00, md};
    return t[W:0];
  endfunction

  logic [W:0]     r_q;
  logic [W-1:0]   sh_q;
  logic [W-1:0]   m_q;
  logic [NBW:0]   cnt_q;
  logic           run_q;
  logic           done_q;
  logic [NBW:0]   shamt;
  logic           last_step;

  assign shamt     = (NBW+1)'(W) - {1'b0, nbits};
  assign last_step = run_q && (cnt_q <= (NBW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q    <= '0;
      sh_q   <= '0;
      m_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (go && !run_q) begin
        r_q   <= '0;
        sh_q  <= val << shamt;
        m_q   <= m;
        cnt_q <= {nbits, 1'b0};
        run_q <= 1'b1;
      end else if (run_q) begin
        r_q   <= red_step(r_q, sh_q[W-1], m_q);
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (last_step) run_q <= 1'b0;
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign res  = r_q[W-1:0];

  a_r3_red_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);
  a_r5_red_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r_q < {1'b0, m_q}));
endmodule

// File: rtl/modexp_mont_mul.sv
module modexp_mont_mul #(
  parameter int W   = 64,
  parameter int NBW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   m,
  input  logic [NBW-1:0] nbits,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   res
);
  localparam int SW = W + 2;

  // one radix-2 Montgomery iteration: add a_i*b, make even with m, halve
  function automatic logic [SW-1:0] mont_step(logic [SW-1:0] s, logic ai,
                                              logic [W-1:0] bb, logic [W-1:0] md);
    logic [SW-1:0] t;
    t = s + (ai ? {2'b00, bb} : '0);
    if (t[0]) t = t + {2'b00, md};
    return t >> 1;
  endfunction

  logic [SW-1:0]  s_q;
  logic [W-1:0]   a_q, b_q, m_q;
  logic [NBW-1:0] cnt_q;
  logic           run_q, fin_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_q;
      if (go && !run_q && !fin_q) begin
        s_q   <= '0;
        a_q   <= a;
        b_q   <= b;
        m_q   <= m;
        cnt_q <= nbits;
        run_q <= 1'b1;
      end else if (run_q) begin
        s_q   <= mont_step(s_q, a_q[0], b_q, m_q);
        a_q   <= a_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q <= NBW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end else if (fin_q) begin
        if (s_q >= {2'b00, m_q}) s_q <= s_q - {2'b00, m_q};
        fin_q <= 1'b0;
      end
    end
  end

  assign busy = run_q | fin_q;
  assign done = done_q;
  assign res  = s_q[W-1:0];

  a_r3_mul_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  a_r3_mul_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (s_q < {2'b00, m_q}));
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
  import modexp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 4,
  localparam int AW       = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int NW_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NW_W-1:0]   n_words,
  output logic              busy,
  output logic              done,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  localparam int MAX_BITS = WORD_W * MAX_WORDS;
  localparam int NBW      = $clog2(MAX_BITS + 1);
  localparam int BIW      = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  function automatic logic [NBW-1:0] len_bits(logic [NW_W-1:0] nw);
    int w;
    w = int'(nw);
    if (w < 1) w = 1;
    if (w > MAX_WORDS) w = MAX_WORDS;
    return NBW'(w * WORD_W);
  endfunction

  function automatic logic [MAX_BITS-1:0] low_mask(logic [NBW-1:0] nb);
    logic [MAX_BITS-1:0] mk;
    for (int i = 0; i < MAX_BITS; i++) mk[i] = (i < int'(nb));
    return mk;
  endfunction

  ctl_state_e          state_q;
  logic [NBW-1:0]      nb_q;
  logic [BIW-1:0]      bidx_q;
  logic [MAX_BITS-1:0] x_q, gr_q;
  logic                pend_q;

  logic [MAX_BITS-1:0] base_v, mod_v, exp_v, mask;
  logic [MAX_BITS-1:0] mod_m, base_m, exp_m;
  logic [WORD_W-1:0]   rdata_op;

  // named internal events
  logic accept_start, e_bit, last_bit, in_mul_st, in_red_st;
  logic mul_go, mul_busy, mul_done, red_go, red_busy, red_done;
  logic [MAX_BITS-1:0] mul_b, red_val, mul_res, red_res;

  assign accept_start = start && (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);

  modexp_store #(.WORD_W(WORD_W), .WORDS(MAX_WORDS), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(host_we && !busy), .sel(host_sel),
    .addr(host_addr), .wdata(host_wdata),
    .base_v(base_v), .mod_v(mod_v), .exp_v(exp_v), .rdata_op(rdata_op)
  );

  assign mask   = low_mask(nb_q);
  assign mod_m  = mod_v & mask;
  assign base_m = base_v & mask;
  assign exp_m  = exp_v & mask;
  assign e_bit    = exp_m[bidx_q];
  assign last_bit = (bidx_q == '0);

  assign in_red_st = (state_q == ST_RED_BASE) || (state_q == ST_RED_ONE);
  assign in_mul_st = (state_q == ST_SQR) || (state_q == ST_MUL) || (state_q == ST_OUT);
  assign red_go    = in_red_st && !pend_q;
  assign mul_go    = in_mul_st && !pend_q;
  assign red_val   = (state_q == ST_RED_BASE) ? base_m : MAX_BITS'(1);

  always_comb begin
    case (state_q)
      ST_MUL:  mul_b = gr_q;
      ST_OUT:  mul_b = MAX_BITS'(1);
      default: mul_b = x_q;
    endcase
  end

  modexp_reduce #(.W(MAX_BITS), .NBW(NBW)) u_reduce (
    .clk(clk), .rst_n(rst_n), .go(red_go), .val(red_val), .m(mod_m),
    .nbits(nb_q), .busy(red_busy), .done(red_done), .res(red_res)
  );

  modexp_mont_mul #(.W(MAX_BITS), .NBW(NBW)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(x_q), .b(mul_b), .m(mod_m),
    .nbits(nb_q), .busy(mul_busy), .done(mul_done), .res(mul_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nb_q    <= NBW'(WORD_W);
      bidx_q  <= '0;
      x_q     <= '0;
      gr_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_start) begin
          nb_q    <= len_bits(n_words);
          pend_q  <= 1'b0;
          state_q <= ST_RED_BASE;
        end
        ST_RED_BASE: if (red_done) begin
          gr_q    <= red_res;
          pend_q  <= 1'b0;
          state_q <= ST_RED_ONE;
        end
        ST_RED_ONE: if (red_done) begin
          x_q     <= red_res;
          pend_q  <= 1'b0;
          bidx_q  <= BIW'(nb_q - 1'b1);
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (e_bit) state_q <= ST_SQR;
          else if (last_bit) state_q <= ST_OUT;
          else bidx_q <= bidx_q - 1'b1;
        end
        ST_SQR, ST_MUL: if (mul_done) begin
          x_q    <= mul_res;
          pend_q <= 1'b0;
          if (state_q == ST_SQR && e_bit) begin
            state_q <= ST_MUL;
          end else if (last_bit) begin
            state_q <= ST_OUT;
          end else begin
            bidx_q  <= bidx_q - 1'b1;
            state_q <= ST_SQR;
          end
        end
        ST_OUT: if (mul_done) begin
          x_q     <= mul_res;
          pend_q  <= 1'b0;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (mul_go || red_go) pend_q <= 1'b1;
    end
  end

  always_comb begin
    if (host_sel == SEL_RES) begin
      host_rdata = (int'(host_addr) < MAX_WORDS)
                   ? x_q[int'(host_addr)*WORD_W +: WORD_W] : '0;
    end else begin
      host_rdata = rdata_op;
    end
  end

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r7_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(base_v) && $stable(mod_v) && $stable(exp_v)));
  a_r3_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (x_q < mod_m));
  a_r3_single_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_busy && red_busy));
endmodule

// File: tb/modexp_engine_test.sv
module modexp_engine_test;
  localparam int WORD_W = 16;
  localparam int MAXW   = 4;
  localparam int AW     = 2;
  localparam int NW_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NW_W-1:0]   n_words = '0;
  logic              busy, done;
  logic              host_we = 1'b0;
  logic [1:0]        host_sel = '0;
  logic [AW-1:0]     host_addr = '0;
  logic [WORD_W-1:0] host_wdata = '0;
  logic [WORD_W-1:0] host_rdata;

  int checks = 0;
  int fails  = 0;

  modexp_engine #(.WORD_W(WORD_W), .MAX_WORDS(MAXW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_words(n_words),
    .busy(busy), .done(done), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] len_mask(int nw);
    return (nw >= 4) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (nw * 16)) - 64'd1);
  endfunction

  // right-to-left square-and-multiply on small moduli
  function automatic longint unsigned model_pow(longint unsigned g, longint unsigned e,
                                                longint unsigned m);
    longint unsigned r, bb;
    r  = 1 % m;
    bb = g % m;
    for (int i = 0; i < 64; i++) begin
      if (e[i]) r = (r * bb) % m;
      bb = (bb * bb) % m;
    end
    return r;
  endfunction

  task automatic wr(int sel, int addr, logic [WORD_W-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'(sel); host_addr = AW'(addr); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(int sel, int addr, output logic [WORD_W-1:0] d);
    @(negedge clk);
    host_sel = 2'(sel); host_addr = AW'(addr);
    #1 d = host_rdata;
  endtask

  task automatic load(int sel, logic [63:0] v);
    for (int k = 0; k < MAXW; k++) wr(sel, k, v[k*16 +: 16]);
  endtask

  task automatic read_res(output logic [63:0] v);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < MAXW; k++) begin
      host_sel = 2'd3; host_addr = AW'(k);
      #1 w = host_rdata;
      v[k*16 +: 16] = w;
    end
  endtask

  // full operation; upper words beyond nw carry garbage (R9)
  task automatic run_op(string req, int nw, logic [63:0] g, logic [63:0] m,
                        logic [63:0] e, bit interfere);
    logic [63:0] mk, res, expv, garb;
    logic [WORD_W-1:0] w;
    int cyc;
    bit seen;
    mk   = len_mask(nw);
    garb = {$urandom, $urandom};
    load(0, (g & mk) | (garb & ~mk));
    load(1, (m & mk) | (~garb & ~mk));
    load(2, (e & mk) | ({garb[31:0], garb[63:32]} & ~mk));
    @(negedge clk);
    n_words = NW_W'(nw);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R6 busy after start"}, 64'(busy), 64'd1);
    cyc = 0; seen = 0;
    while (!seen && cyc < 20000) begin
      if (interfere && cyc == 5) begin
        host_we = 1'b1; host_sel = 2'd1; host_addr = '0; host_wdata = 16'hFFFF;
        start = 1'b1;
      end else begin
        host_we = 1'b0; start = 1'b0;
      end
      #1;
      if (done) seen = 1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    host_we = 1'b0; start = 1'b0;
    if (!seen) begin
      checks++; fails++;
      $display("FAIL watchdog %s: actual no done expected done", req);
      return;
    end
    read_res(res);
    expv = model_pow(g & mk, e & mk, m & mk);
    check({req, " R3 result"}, res, expv);
    @(negedge clk);
    check({req, " R6 done one cycle"}, {62'd0, done, busy}, 64'd0);
    if (interfere) begin
      rd(1, 0, w);
      check({req, " R7 write ignored while busy"}, 64'(w), 64'(m[15:0]));
      repeat (3) @(negedge clk);
      check({req, " R8 start ignored while busy"}, 64'(busy), 64'd0);
    end
  endtask

  initial begin
    logic [WORD_W-1:0] w;
    logic [63:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy at reset", 64'(busy), 64'd0);
    check("R1 done at reset", 64'(done), 64'd0);
    read_res(v);
    check("R1 result cleared", v, 64'd0);
    rst_n = 1'b1;

    wr(1, 2, 16'hA5C3);
    rd(1, 2, w);
    check("R2 modulus word readback", 64'(w), 64'hA5C3);
    wr(2, 0, 16'h1234);
    rd(2, 0, w);
    check("R2 exponent word readback", 64'(w), 64'h1234);
    wr(3, 0, 16'hBEEF);
    rd(3, 0, w);
    check("R2 result not host writable", 64'(w), 64'd0);

    run_op("R4 zero exponent",      1, 64'd2,   64'd157, 64'd0,     0);
    run_op("R3 exponent one",       1, 64'd2,   64'd157, 64'd1,     0);
    run_op("R3 g2 p157",            1, 64'd2,   64'd157, 64'd43,    0);
    run_op("R5 base above modulus", 1, 64'd500, 64'd157, 64'd77,    0);
    run_op("R3 all-ones exponent",  1, 64'd3,   64'd157, 64'hFFFF,  0);
    run_op("R4 modulus one",        2, 64'd9,   64'd1,   64'd5,     0);
    run_op("R9 length two",         2, 64'h1_0003, 64'h7FFF_FFED,
           64'h8000_0001, 0);
    run_op("R3 full length",        4, 64'hDEAD_BEEF_1234_5678,
           64'h6FFF_FFF1, 64'h8000_0000_0000_0003, 0);
    run_op("R7 R8 mid-run access",  1, 64'd5,   64'd157, 64'h00F3,  1);

    for (int t = 0; t < 12; t++) begin
      int nw;
      logic [63:0] mk, mm;
      nw = 1 + int'($urandom % 4);
      mk = len_mask(nw);
      mm = {32'd0, $urandom} & mk & 64'h7FFF_FFFF;
      mm = mm | 64'd1;
      if (mm < 3) mm = 64'd3;
      run_op("R9 random", nw, {$urandom, $urandom}, mm, {$urandom, $urandom}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule